// File: doc/BRIEF.md
# Four-Register Toy Processor Core

This block is a small processor core that executes one instruction per clock. Its program and data share one internal memory of 256 byte-wide words. It has four general registers, a program counter and a single flag. Instructions come in four classes: memory transfer, register transfer, arithmetic and control flow. A sub-operation field picks the variant within each class. Memory-transfer and control-flow instructions occupy two words, and the second word holds an address. Register and arithmetic instructions occupy one word.

A test environment loads the memory through a load port while the core is halted. It then releases the halt input for a chosen number of clocks and halts the core again. Finally it inspects the program counter, the flag and the registers on dedicated outputs, and reads any memory word through a peek port. The asynchronous active-low reset is released to the core through a two-stage synchronizer. State therefore leaves reset two clocks after `rst_n` rises.

Top module: `quad_core`

## Requirements
- R1: While reset is applied, and once it is released, the program counter, all four registers and the flag C read zero. Asserting `rst_n` low clears them at once, without waiting for a clock. Memory contents are not affected by reset.
- R2: An instruction word is laid out as bits [7:6] class, [5:4] sub-operation, [3:2] destination selector and [1:0] source selector. The address word sits at PC+1. All PC arithmetic wraps modulo 256.
- R3: Class 0 with sub 0 loads the destination register from memory at the address word. Class 0 with sub 1 stores the source register to memory at the address word. Both advance the PC by 2.
- R4: Class 1 with sub 0 copies the source register into the destination. Class 1 with sub 1 writes the bitwise inverse of the source into the destination. Both advance the PC by 1.
- R5: Class 2 with sub 0 adds the source to the destination and sets C to the carry out. Class 2 with sub 1 subtracts the source from the destination and sets C to 1 exactly when the destination was smaller than the source. Both advance the PC by 1.
- R6: Class 3 with sub 0 loads the PC with the address word. Class 3 with sub 1 does the same when C is 1, and otherwise advances the PC by 2.
- R7: C changes only on class 2 instructions whose sub-operation is 0 or 1.
- R8: Registers other than the destination keep their values. Memory changes only on a class 0, sub 1 store, or through the load port.
- R9: Sub-operation values 2 and 3 write nothing and leave C unchanged. They advance the PC by 2 in classes 0 and 3, and by 1 in classes 1 and 2.
- R10: While `halt` is 1, the PC, the registers, C and memory stores are frozen, and the load port writes `ld_data` to memory at `ld_addr` when `ld_en` is 1. While `halt` is 0 the load port is ignored.
- R11: When the destination and source selectors are equal, the operation uses the register's value from before the clock edge. For example, subtracting a register from itself gives 0 with C cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes execution; enables the load port |
| ld_en | input | 1 | Load-port write strobe (honoured only while halted) |
| ld_addr | input | 8 | Load-port memory address |
| ld_data | input | 8 | Load-port write data |
| peek_addr | input | 8 | Memory address to observe |
| peek_data | output | 8 | Memory word at `peek_addr` (combinational) |
| pc_o | output | 8 | Program counter |
| c_o | output | 1 | Flag C |
| regs_o | output | 32 | Registers, R0 in bits [7:0] up to R3 in bits [31:24] |

## Verification
Two things can coincide in one clock: the register file reads an operand and writes back the same register, and the flag updates together with that write. Instructions whose destination equals their source provoke this case, such as a register subtracted from itself and a register added to itself with a carry. The result is judged against the arithmetic on the value held before the edge, and C against that same arithmetic's carry or borrow. A separate program sets C with an add and then passes a register move before a conditional jump, which shows that the flag survives non-arithmetic instructions.

// File: rtl/qcpu_pkg.sv
package qcpu_pkg;

  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_REG = 2'd1,
    CLS_ARI = 2'd2,
    CLS_CTL = 2'd3
  } cls_e;

  typedef enum logic [2:0] {
    WB_MEMRD = 3'd0,
    WB_COPY  = 3'd1,
    WB_INV   = 3'd2,
    WB_SUM   = 3'd3,
    WB_DIFF  = 3'd4
  } wb_e;

  typedef enum logic [1:0] {
    NPC_STEP1  = 2'd0,
    NPC_STEP2  = 2'd1,
    NPC_TARGET = 2'd2
  } npc_e;

  typedef struct packed {
    cls_e       cls;
    logic [1:0] sub;
    logic [1:0] dst;
    logic [1:0] src;
  } ins_t;

  typedef struct packed {
    logic reg_we;
    logic mem_we;
    logic flag_we;
    wb_e  wb;
    npc_e npc;
  } ctl_t;

endpackage

// File: rtl/qcpu_decode.sv
module qcpu_decode
  import qcpu_pkg::*;
(
  input  cls_e       cls,
  input  logic [1:0] sub,
  input  logic       flag_c,
  output ctl_t       ctl
);

  always_comb begin
    ctl.reg_we  = 1'b0;
    ctl.mem_we  = 1'b0;
    ctl.flag_we = 1'b0;
    ctl.wb      = WB_COPY;
    ctl.npc     = NPC_STEP1;
    case (cls)
      CLS_MEM: begin
        ctl.npc = NPC_STEP2;
        if (sub == 2'd0) begin
          ctl.reg_we = 1'b1;
          ctl.wb     = WB_MEMRD;
        end else if (sub == 2'd1) begin
          ctl.mem_we = 1'b1;
        end
      end
      CLS_REG: begin
        if (sub == 2'd0) begin
          ctl.reg_we = 1'b1;
          ctl.wb     = WB_COPY;
        end else if (sub == 2'd1) begin
          ctl.reg_we = 1'b1;
          ctl.wb     = WB_INV;
        end
      end
      CLS_ARI: begin
        if (sub == 2'd0) begin
          ctl.reg_we  = 1'b1;
          ctl.flag_we = 1'b1;
          ctl.wb      = WB_SUM;
        end else if (sub == 2'd1) begin
          ctl.reg_we  = 1'b1;
          ctl.flag_we = 1'b1;
          ctl.wb      = WB_DIFF;
        end
      end
      default: begin
        if (sub == 2'd0) begin
          ctl.npc = NPC_TARGET;
        end else if (sub == 2'd1) begin
          ctl.npc = flag_c ? NPC_TARGET : NPC_STEP2;
        end else begin
          ctl.npc = NPC_STEP2;
        end
      end
    endcase
  end

endmodule

// File: rtl/qcpu_alu.sv
module qcpu_alu
  import qcpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  wb_e           sel,
  input  logic [DW-1:0] dst_val,
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] mem_val,
  output logic [DW-1:0] result,
  output logic          flag_out
);

  logic [DW:0] ext;

  always_comb begin
    case (sel)
      WB_MEMRD: ext = {1'b0, mem_val};
      WB_COPY:  ext = {1'b0, src_val};
      WB_INV:   ext = {1'b0, ~src_val};
      WB_SUM:   ext = {1'b0, dst_val} + {1'b0, src_val};
      WB_DIFF:  ext = {1'b0, dst_val} - {1'b0, src_val};
      default:  ext = '0;
    endcase
  end

  assign result   = ext[DW-1:0];
  assign flag_out = ext[DW];

endmodule

// File: rtl/qcpu_regfile.sv
module qcpu_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SW-1:0]      wsel,
  input  logic [DW-1:0]      wdata,
  input  logic [SW-1:0]      rsel_a,
  input  logic [SW-1:0]      rsel_b,
  output logic [DW-1:0]      rdata_a,
  output logic [DW-1:0]      rdata_b,
  output logic [NREG*DW-1:0] regs_flat
);

  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (wsel == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (en) begin
        q[g] <= wdata;
      end
    end

    assign regs_flat[g*DW +: DW] = q[g];
  end

  assign rdata_a = q[rsel_a];
  assign rdata_b = q[rsel_b];

endmodule

// File: rtl/qcpu_mem.sv
module qcpu_mem #(
  parameter int DW  = 8,
  parameter int AW  = 8,
  parameter int NRD = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = cells[raddr[p]];
  end

endmodule

// File: rtl/quad_core.sv
module quad_core
  import qcpu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt,
  input  logic               ld_en,
  input  logic [AW-1:0]      ld_addr,
  input  logic [DW-1:0]      ld_data,
  input  logic [AW-1:0]      peek_addr,
  output logic [DW-1:0]      peek_data,
  output logic [AW-1:0]      pc_o,
  output logic               c_o,
  output logic [NREG*DW-1:0] regs_o
);

  localparam int SW    = $clog2(NREG);
  localparam int NRD   = 4;
  localparam int P_INS = 0;
  localparam int P_ADR = 1;
  localparam int P_DAT = 2;
  localparam int P_PEEK = 3;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rsync_q[1];

  logic run;
  assign run = ~halt & core_rst_n;

  logic [AW-1:0] pc_q, pc_d;
  logic          c_q, c_d;

  logic [NRD-1:0][AW-1:0] mraddr;
  logic [NRD-1:0][DW-1:0] mrdata;
  logic                   mem_we;
  logic [AW-1:0]          mem_waddr;
  logic [DW-1:0]          mem_wdata;

  ins_t          ins;
  logic [DW-1:0] aword;
  ctl_t          ctl;
  logic [DW-1:0] dst_val, src_val, wb_val;
  logic          alu_flag;

  assign ins   = ins_t'(mrdata[P_INS][7:0]);
  assign aword = mrdata[P_ADR];

  assign mraddr[P_INS]  = pc_q;
  assign mraddr[P_ADR]  = pc_q + AW'(1);
  assign mraddr[P_DAT]  = aword[AW-1:0];
  assign mraddr[P_PEEK] = peek_addr;

  // memory write source: load port while halted, core store while running
  assign mem_we    = halt ? ld_en : (run & ctl.mem_we);
  assign mem_waddr = halt ? ld_addr : aword[AW-1:0];
  assign mem_wdata = halt ? ld_data : src_val;

  qcpu_mem #(.DW(DW), .AW(AW), .NRD(NRD)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mraddr),
    .rdata (mrdata)
  );

  qcpu_decode u_dec (
    .cls    (ins.cls),
    .sub    (ins.sub),
    .flag_c (c_q),
    .ctl    (ctl)
  );

  qcpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .we        (run & ctl.reg_we),
    .wsel      (SW'(ins.dst)),
    .wdata     (wb_val),
    .rsel_a    (SW'(ins.dst)),
    .rsel_b    (SW'(ins.src)),
    .rdata_a   (dst_val),
    .rdata_b   (src_val),
    .regs_flat (regs_o)
  );

  qcpu_alu #(.DW(DW)) u_alu (
    .sel      (ctl.wb),
    .dst_val  (dst_val),
    .src_val  (src_val),
    .mem_val  (mrdata[P_DAT]),
    .result   (wb_val),
    .flag_out (alu_flag)
  );

  // next-state logic
  always_comb begin
    case (ctl.npc)
      NPC_STEP2:  pc_d = pc_q + AW'(2);
      NPC_TARGET: pc_d = aword[AW-1:0];
      default:    pc_d = pc_q + AW'(1);
    endcase
    c_d = ctl.flag_we ? alu_flag : c_q;
  end

  // state registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
      c_q  <= 1'b0;
    end else if (run) begin
      pc_q <= pc_d;
      c_q  <= c_d;
    end
  end

  assign pc_o      = pc_q;
  assign c_o       = c_q;
  assign peek_data = mrdata[P_PEEK];

endmodule

// File: rtl/quad_core_checker.sv
module quad_core_checker #(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               halt,
  input logic               run,
  input logic [1:0]         cls,
  input logic [1:0]         sub,
  input logic [1:0]         dst,
  input logic [DW-1:0]      aword,
  input logic [AW-1:0]      pc,
  input logic               c,
  input logic [NREG*DW-1:0] regs
);

  // R10: a halted core keeps its architectural state
  p_frozen_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(pc) && $stable(c) && $stable(regs)));

  // R3: memory-class instructions are two words long
  p_mem_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cls == 2'd0) |=> (pc == AW'($past(pc) + AW'(2))));

  // R4/R5: register and arithmetic classes are one word long
  p_reg_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cls == 2'd1 || cls == 2'd2)) |=> (pc == AW'($past(pc) + AW'(1))));

  // R6: unconditional jump lands on the address word
  p_jump_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cls == 2'd3 && sub == 2'd0) |=> (pc == $past(aword[AW-1:0])));

  // R7: only arithmetic touches the flag
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cls != 2'd2) |=> $stable(c));

  // R9: reserved arithmetic sub-operations leave the flag alone
  p_nop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cls == 2'd2 && sub[1]) |=> $stable(c));

  // R8: registers that are not the destination keep their value
  for (genvar g = 0; g < NREG; g++) begin : g_keep
    p_keep_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (cls == 2'd1 || cls == 2'd2) && dst != 2'(g))
        |=> $stable(regs[g*DW +: DW]));
  end

endmodule

bind quad_core quad_core_checker #(.DW(DW), .AW(AW), .NREG(NREG)) u_chk (
  .clk   (clk),
  .rst_n (core_rst_n),
  .halt  (halt),
  .run   (run),
  .cls   (ins.cls),
  .sub   (ins.sub),
  .dst   (ins.dst),
  .aword (aword),
  .pc    (pc_q),
  .c     (c_q),
  .regs  (regs_o)
);

// File: tb/quad_core_bench.sv
`timescale 1ns/1ps
module quad_core_bench;

  localparam int DEPTH = 256;
  localparam int NV    = 15;

  // {instruction, address word, R0, R1, R2, R3 initial}
  localparam logic [47:0] VEC [NV] = '{
    48'h08F1_1122_3344,
    48'h13E0_1122_3344,
    48'h4300_0506_0708,
    48'h5600_0506_0F08,
    48'h8E00_0102_1025,
    48'h8100_F020_0000,
    48'h9900_0003_0900,
    48'h9600_0003_0900,
    48'hC040_0102_0304,
    48'hD040_0102_0304,
    48'h6000_0102_0304,
    48'h30E0_0102_0304,
    48'h9500_007B_0000,
    48'h8A00_0000_9000,
    48'hA600_0102_0304
  };

  logic        clk = 1'b0;
  logic        rst_n, halt, ld_en;
  logic [7:0]  ld_addr, ld_data, peek_addr, peek_data, pc_o;
  logic        c_o;
  logic [31:0] regs_o;

  quad_core u_quad_core (
    .clk(clk), .rst_n(rst_n), .halt(halt), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .peek_addr(peek_addr),
    .peek_data(peek_data), .pc_o(pc_o), .c_o(c_o), .regs_o(regs_o)
  );

  always #2.5 clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  logic [7:0] image [DEPTH];
  logic [7:0] er [4];
  logic [7:0] epc, esa, esv;
  logic       ec, est;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    peek_addr = a;
    #0.5;
    d = peek_data;
  endtask

  task automatic fill_bg();
    for (int i = 0; i < DEPTH; i++) image[i] = 8'(i) ^ 8'h5A;
  endtask

  task automatic load_all();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = image[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic start();
    halt = 1'b1; rst_n = 1'b0;
    load_all();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input int n);
    halt = 1'b0;
    repeat (n) @(negedge clk);
    halt = 1'b1;
  endtask

  // expected effect of one instruction at address 8, C=0 beforehand
  task automatic model(input logic [7:0] ins, input logic [7:0] aw);
    logic [1:0] op, b, d, s;
    logic [8:0] w;
    op = ins[7:6]; b = ins[5:4]; d = ins[3:2]; s = ins[1:0];
    ec = 1'b0; est = 1'b0; esa = 8'hE0; esv = 8'h00;
    case (op)
      2'd0: begin
        epc = 8'd10;
        if (b == 2'd0) er[d] = image[aw];
        else if (b == 2'd1) begin est = 1'b1; esa = aw; esv = er[s]; end
      end
      2'd1: begin
        epc = 8'd9;
        if (b == 2'd0) er[d] = er[s];
        else if (b == 2'd1) er[d] = ~er[s];
      end
      2'd2: begin
        epc = 8'd9;
        if (b == 2'd0) begin
          w = {1'b0, er[d]} + {1'b0, er[s]}; er[d] = w[7:0]; ec = w[8];
        end else if (b == 2'd1) begin
          ec = (er[d] < er[s]); er[d] = er[d] - er[s];
        end
      end
      default: begin
        if (b == 2'd0) epc = aw;
        else epc = 8'd10;
      end
    endcase
  endtask

  function automatic string tag_of(input logic [7:0] ins);
    if (ins[5:4] >= 2'd2) return "R9";
    if (ins[7:6] == 2'd2 && ins[3:2] == ins[1:0]) return "R11";
    case (ins[7:6])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ins, aw, v;
    logic [7:0] r0 [4];
    string tg;
    rst_n = 1'b0; halt = 1'b1; ld_en = 1'b0;
    ld_addr = '0; ld_data = '0; peek_addr = '0;

    // ---- R1: state after reset
    fill_bg();
    start();
    chk("R1 pc after reset", 32'(pc_o), 32'h0);
    chk("R1 flag after reset", 32'(c_o), 32'h0);
    chk("R1 regs after reset", regs_o, 32'h0);

    // ---- R10: held halt keeps PC at zero
    repeat (10) @(negedge clk);
    chk("R10 pc frozen under halt", 32'(pc_o), 32'h0);

    // ---- table of single-instruction vectors (R2 field layout)
    for (int t = 0; t < NV; t++) begin
      {ins, aw, r0[0], r0[1], r0[2], r0[3]} = VEC[t];
      fill_bg();
      for (int i = 0; i < 4; i++) begin
        image[2*i]        = 8'(i << 2);
        image[2*i + 1]    = 8'hF0 + 8'(i);
        image[8'hF0 + i]  = r0[i];
        er[i]             = r0[i];
      end
      image[8] = ins;
      image[9] = aw;
      model(ins, aw);
      tg = tag_of(ins);
      start();
      run(5);
      chk($sformatf("%s vec%0d pc", tg, t), 32'(pc_o), 32'(epc));
      chk($sformatf("%s vec%0d flag", tg, t), 32'(c_o), 32'(ec));
      chk($sformatf("%s vec%0d regs", tg, t), regs_o, {er[3], er[2], er[1], er[0]});
      peek(esa, v);
      if (est) chk($sformatf("R3 vec%0d stored word", t), 32'(v), 32'(esv));
      else     chk($sformatf("R8 vec%0d memory untouched", t), 32'(v), 32'(image[8'hE0]));
    end

    // ---- R6/R7: add sets C, a move keeps it, conditional jump taken
    fill_bg();
    image[0] = 8'h00; image[1] = 8'hF0;
    image[2] = 8'h04; image[3] = 8'hF1;
    image[4] = 8'h81;
    image[5] = 8'h48;
    image[6] = 8'hD0; image[7] = 8'h40;
    image[8'hF0] = 8'hFF; image[8'hF1] = 8'h01;
    start();
    run(3);
    chk("R5 carry out of FF+01", 32'(c_o), 32'h1);
    run(1);
    chk("R7 flag kept across move", 32'(c_o), 32'h1);
    run(1);
    chk("R6 conditional jump taken", 32'(pc_o), 32'h40);
    chk("R5 regs after carry program", regs_o, 32'h0000_0100);

    // ---- R10: halt mid-program, load port ignored while running
    fill_bg();
    for (int i = 0; i < 4; i++) begin
      image[2*i] = 8'(i << 2); image[2*i + 1] = 8'hF0 + 8'(i);
      image[8'hF0 + i] = 8'h10 + 8'(i);
    end
    start();
    halt = 1'b0;
    ld_en = 1'b1; ld_addr = 8'hE0; ld_data = ~image[8'hE0];
    repeat (2) @(negedge clk);
    ld_en = 1'b0;
    halt = 1'b1;
    chk("R10 pc after two steps", 32'(pc_o), 32'h4);
    repeat (6) @(negedge clk);
    chk("R10 pc held", 32'(pc_o), 32'h4);
    chk("R10 regs held", regs_o, 32'h0000_1110);
    peek(8'hE0, v);
    chk("R10 load port ignored while running", 32'(v), 32'(image[8'hE0]));

    // ---- R1: asynchronous reset mid-run
    run(2);
    chk("R1 progress before reset", 32'(pc_o), 32'h8);
    rst_n = 1'b0;
    #0.5;
    chk("R1 pc cleared without clock", 32'(pc_o), 32'h0);
    chk("R1 regs cleared without clock", regs_o, 32'h0);
    peek(8'hF1, v);
    chk("R1 memory kept through reset", 32'(v), 32'h11);

    // ---- R2: PC wraps modulo 256
    fill_bg();
    image[0] = 8'hC0; image[1] = 8'hFF;
    image[8'hFF] = 8'h40;
    start();
    run(2);
    chk("R2 pc wraps past FF", 32'(pc_o), 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule